// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight condition and control flags of a small 8-bit processor core, together with all the logic that updates them. The arithmetic unit delivers new flag values through a per-flag write-enable mask. The instruction stream is decoded here for four groups of operations: the single-word flag set and clear opcodes, the return-from-interrupt opcode, and the two bit-transfer instructions that move one register bit into the transfer flag T and back. A data-space port lets software load and read the whole register. An interrupt-accept strobe drops the global interrupt enable.

The sign flag is never stored from any source. It is always rebuilt as the XOR of the negative and overflow flags that the register will hold next. As a result, the invariant holds in every cycle, whatever the write sources request.

Top module: `psw_unit`

## Requirements
- R1: After reset all eight flags read 0. The layout is I=bit 7, T=bit 6, H=bit 5, S=bit 4, V=bit 3, N=bit 2, Z=bit 1, C=bit 0.
- R2: In every cycle S equals N XOR V of the stored value. A value offered for S by the arithmetic mask, by a set/clear opcode or by a bus write has no effect.
- R3: `alu_we[k]` (k = 0..5, bit k of the register) loads `alu_val[k]` into flag k at the next edge. Flags whose enable is low keep their value.
- R4: With `op_valid` high, opcode 0x9408 + 0x10*k sets flag k and opcode 0x9488 + 0x10*k clears flag k (k = 0..7). Any other opcode leaves the flags untouched, apart from R8 to R9.
- R5: A write with `bus_wr` high at data address 0x005F loads all flags from `bus_wdata` (S per R2). A write to any other address does nothing. `bus_rdata` shows the current flags while `bus_addr` is 0x005F, and 0x00 otherwise.
- R6: When a bus write, an arithmetic update and a flag opcode fall in the same cycle, the bus write decides every bit except I under R7 to R8.
- R7: `irq_take` clears I at the next edge, whatever else happens in that cycle.
- R8: With `op_valid` high, opcode 0x9518 sets I at the next edge unless `irq_take` is also high.
- R9: With `op_valid` high, an opcode matching 1111_101x_xxxx_0bbb copies `rd_value[bbb]` into T.
- R10: With `op_valid` high, an opcode matching 1111_100x_xxxx_0bbb raises `bld_wr` in the same cycle. `bld_result` then equals `rd_value` with bit bbb replaced by the current T.
- R11: With `op_valid` low the opcode is ignored: no flag changes through it and `bld_wr` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Opcode on `opcode` is being executed this cycle |
| opcode | input | 16 | Current instruction word |
| alu_we | input | 6 | Per-flag write enables for bits 5..0 |
| alu_val | input | 6 | Flag values from the arithmetic unit, bits 5..0 |
| irq_take | input | 1 | Interrupt accepted this cycle |
| rd_value | input | 8 | Register operand for bit store / bit load |
| bus_addr | input | 16 | Data-space address |
| bus_wr | input | 1 | Bus write strobe |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Flags when addressed, else 0 |
| bld_wr | output | 1 | Bit-load result valid |
| bld_result | output | 8 | Operand with selected bit replaced by T |
| flags | output | 8 | Stored flag register |

## Verification
The hardest case to reach is a single cycle in which four sources collide: a bus write, an arithmetic update, an instruction and the interrupt strobe, each requesting a different value for the same bits. The priority order only becomes visible there. The stimulus drives such cycles on purpose: a bus write together with a mask update and a conflicting set opcode, then return-from-interrupt together with the interrupt strobe. After that, several hundred cycles of mixed random traffic compare every flag bit against a behavioural model.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int FLAG_W = 8;
  localparam int ALU_W  = 6;
  localparam int SEL_W  = $clog2(FLAG_W);

  localparam int B_C = 0;
  localparam int B_Z = 1;
  localparam int B_N = 2;
  localparam int B_V = 3;
  localparam int B_S = 4;
  localparam int B_H = 5;
  localparam int B_T = 6;
  localparam int B_I = 7;

  typedef logic [FLAG_W-1:0] flags_t;

  // single-word flag set/clear family: 1001_0100_cbbb_1000
  function automatic logic f_is_flag_op(input logic [15:0] op);
    return (op[15:8] == 8'h94) && (op[3:0] == 4'h8);
  endfunction

  function automatic logic f_is_reti(input logic [15:0] op);
    return op == 16'h9518;
  endfunction

  function automatic logic f_is_bst(input logic [15:0] op);
    return (op & 16'hFE08) == 16'hFA00;
  endfunction

  function automatic logic f_is_bld(input logic [15:0] op);
    return (op & 16'hFE08) == 16'hF800;
  endfunction

  function automatic flags_t f_put_bit(input flags_t v, input logic [SEL_W-1:0] idx,
                                       input logic b);
    flags_t r;
    r = v;
    r[idx] = b;
    return r;
  endfunction

  function automatic logic f_sign(input logic n, input logic ovf);
    return n ^ ovf;
  endfunction
endpackage

// File: rtl/psw_decode.sv
module psw_decode
  import psw_pkg::*;
(
  input  logic             op_valid,
  input  logic [15:0]      opcode,
  output logic             flag_hit,
  output logic             flag_clr,
  output logic [SEL_W-1:0] flag_idx,
  output logic             reti_hit,
  output logic             bst_hit,
  output logic             bld_hit,
  output logic [SEL_W-1:0] bit_sel
);
  assign flag_hit = op_valid && f_is_flag_op(opcode);
  assign flag_clr = opcode[7];
  assign flag_idx = opcode[6:4];
  assign reti_hit = op_valid && f_is_reti(opcode);
  assign bst_hit  = op_valid && f_is_bst(opcode);
  assign bld_hit  = op_valid && f_is_bld(opcode);
  assign bit_sel  = opcode[2:0];
endmodule

// File: rtl/psw_next.sv
module psw_next
  import psw_pkg::*;
(
  input  flags_t           cur,
  input  logic [ALU_W-1:0] alu_we,
  input  logic [ALU_W-1:0] alu_val,
  input  logic             flag_hit,
  input  logic             flag_clr,
  input  logic [SEL_W-1:0] flag_idx,
  input  logic             bst_hit,
  input  logic             bst_bit,
  input  logic             bus_wr_hit,
  input  flags_t           bus_wdata,
  input  logic             reti_hit,
  input  logic             irq_take,
  output flags_t           nxt
);
  flags_t stage;

  for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
    logic v_alu;
    logic v_fin;
    if (b < ALU_W) begin : g_alu
      assign v_alu = alu_we[b] ? alu_val[b] : cur[b];
    end else begin : g_keep
      assign v_alu = cur[b];
    end
    always_comb begin
      v_fin = v_alu;
      if (b == B_T && bst_hit) v_fin = bst_bit;
      if (flag_hit && flag_idx == SEL_W'(b)) v_fin = ~flag_clr;
      if (bus_wr_hit) v_fin = bus_wdata[b];
      if (b == B_I && reti_hit) v_fin = 1'b1;
      if (b == B_I && irq_take) v_fin = 1'b0;
    end
    assign stage[b] = v_fin;
  end

  // requested S value is discarded: S is rebuilt from N and V
  logic s_request_unused;
  assign s_request_unused = stage[B_S];

  always_comb begin
    nxt      = stage;
    nxt[B_S] = f_sign(stage[B_N], stage[B_V]);
  end
endmodule

// File: rtl/psw_busport.sv
module psw_busport
  import psw_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] REG_ADDR  = 16'h005F
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  flags_t            cur,
  output logic              bus_wr_hit,
  output flags_t            bus_rdata
);
  logic sel;
  assign sel        = (bus_addr == ADDR_W'(REG_ADDR));
  assign bus_wr_hit = sel && bus_wr;
  assign bus_rdata  = sel ? cur : '0;
endmodule

// File: rtl/psw_unit.sv
module psw_unit
  import psw_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] REG_ADDR = 16'h005F
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic [15:0]          opcode,
  input  logic [ALU_W-1:0]     alu_we,
  input  logic [ALU_W-1:0]     alu_val,
  input  logic                 irq_take,
  input  logic [FLAG_W-1:0]    rd_value,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [FLAG_W-1:0]    bus_wdata,
  output logic [FLAG_W-1:0]    bus_rdata,
  output logic                 bld_wr,
  output logic [FLAG_W-1:0]    bld_result,
  output logic [FLAG_W-1:0]    flags
);
  flags_t           flag_q;
  flags_t           flag_d;
  logic             flag_hit;
  logic             flag_clr;
  logic [SEL_W-1:0] flag_idx;
  logic             reti_hit;
  logic             bst_hit;
  logic             bld_hit;
  logic [SEL_W-1:0] bit_sel;
  logic             bus_wr_hit;
  logic             bst_bit;

  psw_decode u_decode (
    .op_valid (op_valid),
    .opcode   (opcode),
    .flag_hit (flag_hit),
    .flag_clr (flag_clr),
    .flag_idx (flag_idx),
    .reti_hit (reti_hit),
    .bst_hit  (bst_hit),
    .bld_hit  (bld_hit),
    .bit_sel  (bit_sel)
  );

  psw_busport #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_bus (
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .cur        (flag_q),
    .bus_wr_hit (bus_wr_hit),
    .bus_rdata  (bus_rdata)
  );

  assign bst_bit = rd_value[bit_sel];

  psw_next u_next (
    .cur        (flag_q),
    .alu_we     (alu_we),
    .alu_val    (alu_val),
    .flag_hit   (flag_hit),
    .flag_clr   (flag_clr),
    .flag_idx   (flag_idx),
    .bst_hit    (bst_hit),
    .bst_bit    (bst_bit),
    .bus_wr_hit (bus_wr_hit),
    .bus_wdata  (bus_wdata),
    .reti_hit   (reti_hit),
    .irq_take   (irq_take),
    .nxt        (flag_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flags      = flag_q;
  assign bld_wr     = bld_hit;
  assign bld_result = f_put_bit(rd_value, bit_sel, flag_q[B_T]);
endmodule

// File: rtl/psw_checks.sv
module psw_checks (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  flags,
  input logic        irq_take,
  input logic        reti_hit,
  input logic        bus_wr_hit,
  input logic [7:0]  bus_wdata,
  input logic        op_valid,
  input logic [5:0]  alu_we,
  input logic        bld_wr,
  input logic [7:0]  bld_result,
  input logic [15:0] opcode
);
  logic quiet;
  assign quiet = !bus_wr_hit && !irq_take && !op_valid && (alu_we == 6'd0);

  a_r2_sign_xor: assert property (@(posedge clk) disable iff (!rst_n)
    flags[4] == (flags[2] ^ flags[3]));

  a_r7_irq_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !flags[7]);

  a_r8_reti_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_hit && !irq_take) |=> flags[7]);

  a_r6_bus_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_hit && !irq_take && !reti_hit) |=> (((flags ^ $past(bus_wdata)) & 8'hEF) == 8'h00));

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> $stable(flags));

  a_r10_bld_t: assert property (@(posedge clk) disable iff (!rst_n)
    bld_wr |-> (bld_result[opcode[2:0]] == flags[6]));
endmodule

bind psw_unit psw_checks u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .flags      (flags),
  .irq_take   (irq_take),
  .reti_hit   (reti_hit),
  .bus_wr_hit (bus_wr_hit),
  .bus_wdata  (bus_wdata),
  .op_valid   (op_valid),
  .alu_we     (alu_we),
  .bld_wr     (bld_wr),
  .bld_result (bld_result),
  .opcode     (opcode)
);

// File: tb/psw_unit_bench.sv
`timescale 1ns/1ps
module psw_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [15:0] opcode = 16'h0000;
  logic [5:0]  alu_we = 6'd0;
  logic [5:0]  alu_val = 6'd0;
  logic        irq_take = 1'b0;
  logic [7:0]  rd_value = 8'd0;
  logic [15:0] bus_addr = 16'd0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = 8'd0;
  logic [7:0]  bus_rdata;
  logic        bld_wr;
  logic [7:0]  bld_result;
  logic [7:0]  flags;

  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 0;
  logic [7:0] model = 8'd0;

  always #2.5 clk = ~clk;

  psw_unit u_psw_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .alu_we(alu_we), .alu_val(alu_val), .irq_take(irq_take), .rd_value(rd_value),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bld_wr(bld_wr), .bld_result(bld_result), .flags(flags)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural reference for one cycle
  function automatic logic [7:0] model_next(input logic [7:0] cur, input logic ov,
      input logic [15:0] op, input logic [5:0] we, input logic [5:0] av, input logic bw,
      input logic [15:0] addr, input logic [7:0] wd, input logic irq, input logic [7:0] rv);
    logic [7:0] n;
    int k;
    n = cur;
    for (int i = 0; i < 6; i++) if (we[i]) n[i] = av[i];
    if (ov) begin
      if (op >= 16'h9408 && op <= 16'h94F8 && ((op - 16'h9408) % 16) == 0) begin
        k = (op - 16'h9408) / 16;
        if (k < 8) n[k] = 1'b1;
        else       n[k-8] = 1'b0;
      end
      if ((op & 16'hFE08) == 16'hFA00) n[6] = rv[op[2:0]];
    end
    if (bw && addr == 16'h005F) n = wd;
    if (ov && op == 16'h9518) n[7] = 1'b1;
    if (irq) n[7] = 1'b0;
    n[4] = n[2] ^ n[3];
    return n;
  endfunction

  task automatic step(input string req, input logic ov, input logic [15:0] op,
      input logic [5:0] we, input logic [5:0] av, input logic bw, input logic [15:0] addr,
      input logic [7:0] wd, input logic irq, input logic [7:0] rv);
    logic [7:0] exp_res;
    logic       exp_bld;
    @(negedge clk);
    op_valid = ov; opcode = op; alu_we = we; alu_val = av; bus_wr = bw;
    bus_addr = addr; bus_wdata = wd; irq_take = irq; rd_value = rv;
    #1;
    chk(req, "bus_rdata", {8'h00, bus_rdata}, (addr == 16'h005F) ? {8'h00, model} : 16'h0000);
    exp_bld = ov && ((op & 16'hFE08) == 16'hF800);
    chk(req, "bld_wr", {15'd0, bld_wr}, {15'd0, exp_bld});
    if (exp_bld) begin
      exp_res = rv;
      exp_res[op[2:0]] = model[6];
      chk(req, "bld_result", {8'h00, bld_result}, {8'h00, exp_res});
    end
    model = model_next(model, ov, op, we, av, bw, addr, wd, irq, rv);
    @(posedge clk); #1;
    chk(req, "flags", {8'h00, flags}, {8'h00, model});
  endtask

  task automatic idle(input string req);
    step(req, 1'b0, 16'h0000, 6'd0, 6'd0, 1'b0, 16'h0000, 8'h00, 1'b0, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "flags in reset", {8'h00, flags}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    idle("R1");

    // R4 set each flag, then clear each; setting S alone must not stick (R2)
    for (int k = 0; k < 8; k++)
      step("R4", 1'b1, 16'(16'h9408 + 16'h10 * k), 6'd0, 6'd0, 1'b0, 16'h0, 8'h0, 1'b0, 8'h0);
    step("R2", 1'b1, 16'h9448, 6'd0, 6'd0, 1'b0, 16'h0, 8'h0, 1'b0, 8'h0);
    for (int k = 0; k < 8; k++)
      step("R4", 1'b1, 16'(16'h9488 + 16'h10 * k), 6'd0, 6'd0, 1'b0, 16'h0, 8'h0, 1'b0, 8'h0);
    step("R2", 1'b1, 16'h9448, 6'd0, 6'd0, 1'b0, 16'h0, 8'h0, 1'b0, 8'h0);
    step("R4", 1'b1, 16'h0000, 6'd0, 6'd0, 1'b0, 16'h0, 8'h0, 1'b0, 8'h0);

    // R11 opcode ignored without op_valid
    step("R11", 1'b0, 16'h9408, 6'd0, 6'd0, 1'b0, 16'h0, 8'h0, 1'b0, 8'h0);
    step("R11", 1'b0, 16'hF807, 6'd0, 6'd0, 1'b0, 16'h0, 8'h0, 1'b0, 8'h0);

    // R3 masked arithmetic updates; S offered through the mask is ignored (R2)
    step("R3", 1'b0, 16'h0, 6'b001111, 6'b001010, 1'b0, 16'h0, 8'h0, 1'b0, 8'h0);
    step("R3", 1'b0, 16'h0, 6'b100001, 6'b111111, 1'b0, 16'h0, 8'h0, 1'b0, 8'h0);
    step("R2", 1'b0, 16'h0, 6'b010000, 6'b000000, 1'b0, 16'h0, 8'h0, 1'b0, 8'h0);
    step("R3", 1'b0, 16'h0, 6'b000100, 6'b000100, 1'b0, 16'h0, 8'h0, 1'b0, 8'h0);

    // R5 bus writes and reads
    step("R5", 1'b0, 16'h0, 6'd0, 6'd0, 1'b1, 16'h005F, 8'hFF, 1'b0, 8'h0);
    step("R5", 1'b0, 16'h0, 6'd0, 6'd0, 1'b1, 16'h003F, 8'h00, 1'b0, 8'h0);
    step("R5", 1'b0, 16'h0, 6'd0, 6'd0, 1'b1, 16'h005E, 8'h00, 1'b0, 8'h0);
    step("R5", 1'b0, 16'h0, 6'd0, 6'd0, 1'b1, 16'h005F, 8'h13, 1'b0, 8'h0);
    step("R5", 1'b0, 16'h0, 6'd0, 6'd0, 1'b0, 16'h005F, 8'h00, 1'b0, 8'h0);

    // R6 bus beats arithmetic and flag opcode in one cycle
    step("R6", 1'b1, 16'h9408, 6'b111111, 6'b111111, 1'b1, 16'h005F, 8'h40, 1'b0, 8'h0);
    step("R6", 1'b1, 16'h94B8, 6'b001000, 6'b001000, 1'b1, 16'h005F, 8'h08, 1'b0, 8'h0);

    // R7 / R8 interrupt enable
    step("R8", 1'b1, 16'h9518, 6'd0, 6'd0, 1'b0, 16'h0, 8'h0, 1'b0, 8'h0);
    step("R7", 1'b0, 16'h0, 6'd0, 6'd0, 1'b0, 16'h0, 8'h0, 1'b1, 8'h0);
    step("R7", 1'b1, 16'h9518, 6'd0, 6'd0, 1'b1, 16'h005F, 8'h80, 1'b1, 8'h0);
    step("R8", 1'b1, 16'h9518, 6'd0, 6'd0, 1'b1, 16'h005F, 8'h00, 1'b0, 8'h0);

    // R9 bit store over every bit position
    for (int b = 0; b < 8; b++) begin
      step("R9", 1'b1, 16'(16'hFA00 | b), 6'd0, 6'd0, 1'b0, 16'h0, 8'h0, 1'b0, 8'(1 << b));
      step("R9", 1'b1, 16'(16'hFBF0 | b), 6'd0, 6'd0, 1'b0, 16'h0, 8'h0, 1'b0, 8'(~(1 << b)));
    end

    // R10 bit load with T = 0 and T = 1
    step("R10", 1'b1, 16'h94E8, 6'd0, 6'd0, 1'b0, 16'h0, 8'h0, 1'b0, 8'h0);
    for (int b = 0; b < 8; b++)
      step("R10", 1'b1, 16'(16'hF810 | b), 6'd0, 6'd0, 1'b0, 16'h0, 8'h0, 1'b0, 8'hFF);
    step("R10", 1'b1, 16'h9468, 6'd0, 6'd0, 1'b0, 16'h0, 8'h0, 1'b0, 8'h0);
    for (int b = 0; b < 8; b++)
      step("R10", 1'b1, 16'(16'hF900 | b), 6'd0, 6'd0, 1'b0, 16'h0, 8'h0, 1'b0, 8'h00);

    // mixed random traffic against the model
    for (int i = 0; i < 400; i++) begin
      logic [15:0] op;
      int          pick;
      pick = $urandom_range(0, 5);
      case (pick)
        0: op = 16'(16'h9408 + 16'h10 * $urandom_range(0, 15));
        1: op = 16'h9518;
        2: op = 16'(16'hFA00 | $urandom_range(0, 7) | ($urandom_range(0, 31) << 4));
        3: op = 16'(16'hF800 | $urandom_range(0, 7) | ($urandom_range(0, 31) << 4));
        default: op = 16'($urandom);
      endcase
      step("R6", 1'($urandom_range(0, 1)), op, 6'($urandom), 6'($urandom),
           ($urandom_range(0, 7) == 0), ($urandom_range(0, 1) == 0) ? 16'h005F : 16'($urandom),
           8'($urandom), ($urandom_range(0, 9) == 0), 8'($urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule